// File: doc/BRIEF.md
# Direct-Mapped Cache Miss Classifier

This block models only the tag side of a direct-mapped cache and sorts every access it sees into one of four outcomes: a hit, a first-reference (compulsory) miss, a conflict miss, or a capacity miss. It accepts one byte address per cycle through a valid/ready handshake. One cycle later it returns a two-bit result code together with the tag, line index and byte offset fields that it split out of the address.

Classifying a miss needs more than the direct-mapped tag array, so three structures run side by side. The first is the direct-mapped tag array itself. The second is a bitmap with one bit per memory block, which records whether that block has ever been touched. The third is a shadow fully-associative store with least-recently-used replacement. A block that was touched before and that the direct-mapped array misses is a conflict miss if the shadow store still holds it. If the shadow store has lost it too, it is a capacity miss. The shadow depth and the memory block count are parameters, so a small configuration can produce capacity misses within a short test.

Top module: `miss_classifier`

## Requirements
- R1: The address fields are split as follows, from the most significant bit down. The tag is the top ADDR_W-OFF_W-IDX_W bits, the index is the next IDX_W bits and the offset is the low OFF_W bits. With the default 20/8/5 split, the tag is addr[19:13], the index is addr[12:5] and the offset is addr[4:0]. All three are echoed on the response.
- R2: A request is accepted when req_valid and req_ready are both high, and req_ready is high in every cycle outside reset. rsp_valid is high in exactly the cycle after an accepted request and low otherwise.
- R3: The first reference to a memory block since reset returns code 01 (compulsory), whatever the cache holds.
- R4: An access to a block already referenced returns code 00 (hit) when its direct-mapped line is valid with a matching tag.
- R5: An access to a block already referenced returns code 11 (conflict) when the direct-mapped array misses but a fully-associative LRU store of SH_LINES entries would hold the block.
- R6: An access to a block already referenced returns code 10 (capacity) when both the direct-mapped array and the fully-associative LRU store miss.
- R7: Every accepted access updates all three structures. The direct-mapped line takes the new tag, the block's first-touch bit is set, and the shadow store moves the block to most recently used, evicting the least recently used entry when the block was absent.
- R8: A synchronous active-high reset empties the direct-mapped array, the first-touch bitmap and the shadow store, and holds req_ready low while it is asserted.
- R9: An accepted access that repeats the block of the access accepted in the cycle before is a hit.
- R10: In the default configuration, starting from reset, the block sequence 2, 216, 100, 256, 2048, 728, 256, 216 yields six compulsory misses followed by two conflict misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Result strobe, one cycle after acceptance |
| rsp_code | output | 2 | 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| rsp_tag | output | ADDR_W-OFF_W-IDX_W | Tag field of the accepted address |
| rsp_index | output | IDX_W | Line index field |
| rsp_offset | output | OFF_W | Byte offset field |

## Verification
The lookup of a new request and the state update left by the previous request meet at the same clock edge. A back-to-back request must therefore see the direct-mapped line, the touch bit and the recency order that its predecessor has just written. The bench provokes this by holding req_valid high across consecutive accesses, including the same block twice and blocks that evict one another. A second configuration with four shadow entries runs a pseudo-random stream, and every result is judged against a reference model in the bench that keeps the set of blocks seen, a direct-mapped table and an LRU list.

// File: rtl/cm_pkg.sv
package cm_pkg;

    typedef enum logic [1:0] {
        CODE_HIT  = 2'b00,
        CODE_COLD = 2'b01,
        CODE_CAP  = 2'b10,
        CODE_CONF = 2'b11
    } miss_code_e;

    typedef struct packed {
        logic seen;
        logic dm_hit;
        logic sh_hit;
    } probe_t;

    function automatic miss_code_e classify(input probe_t p);
        if (!p.seen)        return CODE_COLD;
        else if (p.dm_hit)  return CODE_HIT;
        else if (p.sh_hit)  return CODE_CONF;
        else                return CODE_CAP;
    endfunction

endpackage

// File: rtl/cm_dm_tags.sv
module cm_dm_tags #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] vld_q;

    assign hit = vld_q[idx] && (tag_q[idx] == tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (upd) begin
            vld_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd) tag_q[idx] <= tag;
    end

    AST_DM_REFILL_HITS: assert property (@(posedge clk) disable iff (rst)
        upd |=> (vld_q[$past(idx)] && tag_q[$past(idx)] == $past(tag))) else $error("dm refill"); // R7

endmodule

// File: rtl/cm_first_touch.sv
module cm_first_touch #(
    parameter int BLK_W = 15,
    parameter int NBLK  = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mark,
    input  logic [BLK_W-1:0] blk,
    output logic             seen
);
    logic [NBLK-1:0] bits_q;

    assign seen = bits_q[blk];

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (mark) begin
            bits_q[blk] <= 1'b1;
        end
    end

endmodule

// File: rtl/cm_lru_shadow.sv
module cm_lru_shadow #(
    parameter int LINES = 256,
    parameter int BLK_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);
    localparam int RK_W = $clog2(LINES);
    localparam logic [RK_W-1:0] OLDEST = RK_W'(LINES - 1);

    logic [BLK_W-1:0] blk_q  [LINES];
    logic [RK_W-1:0]  rank_q [LINES];
    logic [LINES-1:0] vld_q;
    logic [LINES-1:0] match;
    logic [LINES-1:0] oldest;
    logic [RK_W-1:0]  hit_rank;

    always_comb begin
        hit_rank = '0;
        for (int i = 0; i < LINES; i++) begin
            match[i]  = vld_q[i] && (blk_q[i] == blk);
            oldest[i] = (rank_q[i] == OLDEST);
            if (match[i]) hit_rank = hit_rank | rank_q[i];
        end
    end

    assign hit = |match;

    for (genvar g = 0; g < LINES; g++) begin : g_way
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g]  <= 1'b0;
                rank_q[g] <= RK_W'(g);
            end else if (upd) begin
                if (hit) begin
                    if (match[g])                  rank_q[g] <= '0;
                    else if (rank_q[g] < hit_rank) rank_q[g] <= rank_q[g] + 1'b1;
                end else begin
                    if (oldest[g]) begin
                        rank_q[g] <= '0;
                        vld_q[g]  <= 1'b1;
                    end else begin
                        rank_q[g] <= rank_q[g] + 1'b1;
                    end
                end
            end
        end

        always_ff @(posedge clk) begin
            if (upd && !hit && oldest[g]) blk_q[g] <= blk;
        end
    end

    AST_SHADOW_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)) else $error("shadow duplicate"); // R7
    AST_SHADOW_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest) == 1) else $error("shadow order"); // R7
    AST_SHADOW_HOLDS_LAST: assert property (@(posedge clk) disable iff (rst)
        upd |=> (blk == $past(blk)) |-> hit) else $error("shadow lost mru"); // R7

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
    parameter int ADDR_W   = 20,
    parameter int OFF_W    = 5,
    parameter int IDX_W    = 8,
    parameter int SH_LINES = 1 << IDX_W,
    parameter int NBLK     = 1 << (ADDR_W - OFF_W)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          rsp_valid,
    output logic [1:0]                    rsp_code,
    output logic [ADDR_W-OFF_W-IDX_W-1:0] rsp_tag,
    output logic [IDX_W-1:0]              rsp_index,
    output logic [OFF_W-1:0]              rsp_offset
);
    import cm_pkg::*;

    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W = ADDR_W - OFF_W;

    logic             ready_q;
    logic             acc;
    logic [TAG_W-1:0] f_tag;
    logic [IDX_W-1:0] f_idx;
    logic [OFF_W-1:0] f_off;
    logic [BLK_W-1:0] f_blk;
    probe_t           probe;
    miss_code_e       code;

    assign req_ready = ready_q;
    assign acc       = req_valid && ready_q;
    assign f_off     = req_addr[OFF_W-1:0];
    assign f_idx     = req_addr[OFF_W +: IDX_W];
    assign f_tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign f_blk     = req_addr[ADDR_W-1:OFF_W];

    cm_dm_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dm (
        .clk(clk), .rst(rst), .upd(acc), .idx(f_idx), .tag(f_tag), .hit(probe.dm_hit)
    );

    cm_first_touch #(.BLK_W(BLK_W), .NBLK(NBLK)) u_touch (
        .clk(clk), .rst(rst), .mark(acc), .blk(f_blk), .seen(probe.seen)
    );

    cm_lru_shadow #(.LINES(SH_LINES), .BLK_W(BLK_W)) u_shadow (
        .clk(clk), .rst(rst), .upd(acc), .blk(f_blk), .hit(probe.sh_hit)
    );

    assign code = classify(probe);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            ready_q   <= 1'b1;
            rsp_valid <= acc;
        end
    end

    always_ff @(posedge clk) begin
        if (acc) begin
            rsp_code   <= code;
            rsp_tag    <= f_tag;
            rsp_index  <= f_idx;
            rsp_offset <= f_off;
        end
    end

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid) else $error("missing response"); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid) else $error("spurious response"); // R2
    AST_REPEAT_IS_HIT: assert property (@(posedge clk) disable iff (rst)
        (acc && $past(acc) && f_blk == $past(f_blk)) |=> rsp_code == CODE_HIT) else $error("repeat not hit"); // R9
    AST_REPEAT_NOT_COLD: assert property (@(posedge clk) disable iff (rst)
        (acc && $past(acc) && f_blk == $past(f_blk)) |-> probe.seen) else $error("touch bit lost"); // R3

endmodule

// File: tb/sim_miss_classifier.sv
module sim_miss_classifier;
    localparam int CLK_P = 10;
    localparam int NV = 16;
    localparam int VEC_BLK [NV] = '{2, 216, 100, 256, 2048, 728, 256, 216,
                                    2, 256, 2048, 216, 728, 100, 4096, 4096};
    localparam int VEC_EXP [NV] = '{1, 1, 1, 1, 1, 1, 3, 3,
                                    0, 0, 3, 0, 3, 0, 1, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v0 = 1'b0, v1 = 1'b0;
    logic [19:0] a0 = '0;
    logic [9:0]  a1 = '0;
    logic r0, r1, rv0, rv1;
    logic [1:0] c0, c1;
    logic [6:0] t0;  logic [7:0] i0;  logic [4:0] o0;
    logic [5:0] t1;  logic [1:0] i1;  logic [1:0] o1;

    int checks = 0, fails = 0;

    bit seen_m [0:32767];
    bit dmv_m  [0:255];
    int dmb_m  [0:255];
    int lru_m  [0:255];
    int lru_n;

    always #(CLK_P/2) clk = ~clk;

    miss_classifier u0 (
        .clk(clk), .rst(rst), .req_valid(v0), .req_ready(r0), .req_addr(a0),
        .rsp_valid(rv0), .rsp_code(c0), .rsp_tag(t0), .rsp_index(i0), .rsp_offset(o0)
    );

    miss_classifier #(.ADDR_W(10), .OFF_W(2), .IDX_W(2), .SH_LINES(4)) u1 (
        .clk(clk), .rst(rst), .req_valid(v1), .req_ready(r1), .req_addr(a1),
        .rsp_valid(rv1), .rsp_code(c1), .rsp_tag(t1), .rsp_index(i1), .rsp_offset(o1)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32768; i++) seen_m[i] = 1'b0;
        for (int i = 0; i < 256; i++) dmv_m[i] = 1'b0;
        lru_n = 0;
    endtask

    // Reference: set of seen blocks, direct-mapped table, LRU list (index 0 = MRU)
    function automatic int model_step(input int blk, input int imask, input int lines);
        int code, idx, pos;
        idx = blk & imask;
        pos = -1;
        for (int i = 0; i < lru_n; i++) if (lru_m[i] == blk) pos = i;
        if (!seen_m[blk])                          code = 1;
        else if (dmv_m[idx] && dmb_m[idx] == blk)  code = 0;
        else if (pos >= 0)                         code = 3;
        else                                       code = 2;
        seen_m[blk] = 1'b1;
        dmv_m[idx] = 1'b1;
        dmb_m[idx] = blk;
        if (pos < 0) begin
            if (lru_n < lines) lru_n++;
            pos = lru_n - 1;
        end
        for (int i = pos; i > 0; i--) lru_m[i] = lru_m[i-1];
        lru_m[0] = blk;
        return code;
    endfunction

    // Drive at a negedge, sample at the next negedge; valid stays high for back-to-back.
    task automatic access(input int sel, input int blk, input int off, input int exp, input string req);
        if (sel == 0) begin v0 = 1'b1; a0 = 20'((blk << 5) | off); end
        else          begin v1 = 1'b1; a1 = 10'((blk << 2) | off); end
        @(posedge clk); @(negedge clk);
        if (sel == 0) begin
            check({req, " R2 rsp_valid"}, int'(rv0), 1);
            check(req, int'(c0), exp);
            check("R1 tag",    int'(t0), (blk >> 8) & 127);
            check("R1 index",  int'(i0), blk & 255);
            check("R1 offset", int'(o0), off);
        end else begin
            check({req, " R2 rsp_valid"}, int'(rv1), 1);
            check(req, int'(c1), exp);
            check("R1 tag",    int'(t1), (blk >> 2) & 63);
            check("R1 index",  int'(i1), blk & 3);
            check("R1 offset", int'(o1), off);
        end
    endtask

    task automatic idle();
        v0 = 1'b0; v1 = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 no rsp u0", int'(rv0), 0);
        check("R2 no rsp u1", int'(rv1), 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int unsigned s;
        int b, e;
        model_reset();
        repeat (3) @(negedge clk);
        check("R8 ready low in reset", int'(r0), 0);
        check("R8 ready low in reset u1", int'(r1), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 ready high", int'(r0), 1);
        check("R2 rsp idle after reset", int'(rv0), 0);

        // Table walk, default configuration: R10 then R4/R5/R9/R3
        for (int k = 0; k < NV; k++) begin
            access(0, VEC_BLK[k], (k * 7) % 32, VEC_EXP[k],
                   k < 8 ? "R10 sequence" : (VEC_EXP[k] == 0 ? "R4 hit" :
                   (VEC_EXP[k] == 3 ? "R5 conflict" : "R3 compulsory")));
        end
        idle();

        // Small configuration: capacity misses, R6
        for (int k = 0; k < 5; k++) begin
            e = model_step(k, 3, 4);
            access(1, k, k & 3, e, "R3 compulsory small");
        end
        e = model_step(0, 3, 4);
        check("R6 model agrees", e, 2);
        access(1, 0, 1, 2, "R6 capacity");
        e = model_step(0, 3, 4);
        access(1, 0, 2, e, "R9 back-to-back hit");
        idle();

        // Pseudo-random stream against the reference, R7
        s = 32'h1234_5678;
        for (int k = 0; k < 300; k++) begin
            s = s * 32'd1103515245 + 32'd12345;
            b = int'((s >> 16) & 32'd15);
            e = model_step(b, 3, 4);
            access(1, b, int'((s >> 8) & 32'd3), e, "R7 stream vs model");
            if ((k % 37) == 36) idle();
        end
        idle();

        // Reset clears everything, R8
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R8 ready low", int'(r1), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        model_reset();
        access(0, 2, 0, 1, "R8 cleared u0");
        e = model_step(5, 3, 4);
        access(1, 5, 0, e, "R8 cleared u1");
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule